// File: doc/BRIEF.md
# Perfect-Filter Setup Frame Streamer

This block produces the fixed-length control frame that loads a sixteen-slot exact-match address table into an Ethernet MAC's receive filter. When software or a sequencer pulses the start input, the block captures the 48-bit station address. It then sends the whole table out as a byte stream, one byte per accepted handshake. Every byte it emits is tagged as a setup frame, so that the downstream transmit path treats the bytes as filter contents and not as a packet to put on the wire.

The table has sixteen entries of twelve bytes each. Each entry spreads a six-byte address over three 32-bit little-endian words. Each word carries two address bytes in its low half, and its upper two bytes are zero. Slot 0 always holds the broadcast address. Slots 1 to 15 all repeat the captured station address. The block does not build descriptors and does not move data by DMA.

Top module: `setup_frame_gen`

## Requirements
- R1: After reset, valid and setup_tag are low, and no byte is offered until start is pulsed.
- R2: A byte moves only in a cycle where valid and ready are both high. While ready is low, data, last and valid hold steady.
- R3: A frame is exactly 192 bytes long, and last is high only on byte index 191. After that byte is accepted, valid falls in the next cycle.
- R4: Inside each 12-byte entry, the in-entry offsets 2, 3, 6, 7, 10 and 11 always carry 0x00.
- R5: Entry 0 (byte indices 0 to 11) carries 0xFF at offsets 0, 1, 4, 5, 8 and 9.
- R6: In entries 1 to 15, the in-entry offsets 0, 1, 4, 5, 8 and 9 carry address bytes 0 to 5 in that order. Address byte k is station_addr[8k+7:8k].
- R7: The station address is captured in the cycle start is seen while idle. Changes to station_addr after that cycle do not affect the frame.
- R8: A start that arrives while a frame is in progress is ignored. The frame in flight continues unchanged, and no second frame follows it.
- R9: setup_tag is high exactly while valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame; sampled while idle |
| station_addr | input | 48 | Station address; byte k in bits 8k+7:8k |
| m_data | output | 8 | Frame byte |
| m_valid | output | 1 | Byte offered |
| m_ready | input | 1 | Consumer accepts byte |
| m_last | output | 1 | Final byte of frame |
| setup_tag | output | 1 | Marks stream as filter setup frame |

## Verification
The bench builds the block with its default parameters: 16 entries, 3 words per entry and 4 bytes per word. With these values the full 192-byte frame and the end-of-frame boundary at byte 191 can be checked directly. Random ready stalls, random station addresses and a directed back-to-back run of three frames exercise the handshake. Start pulses during a frame and address changes after capture are applied, to show that neither affects the frame in flight.

// File: rtl/setup_frame_pkg.sv
// Package: shared geometry of the perfect-filter setup frame.
// Assumes each address occupies three 32-bit words, two bytes per word.
package setup_frame_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SEND = 1'b1} fsm_t;
endpackage

// File: rtl/frame_counter.sv
// Module: frame_counter
// Tracks the byte position in the frame as an entry index and an in-entry offset.
// Assumes advance is asserted only for accepted bytes while a frame is active.
module frame_counter #(
    parameter int N_ENTRIES   = 16,
    parameter int ENTRY_BYTES = 12,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int OW = $clog2(ENTRY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [EW-1:0] entry,
    output logic [OW-1:0] offset,
    output logic          at_end
);
    localparam logic [OW-1:0] OFF_MAX = OW'(ENTRY_BYTES - 1);
    localparam logic [EW-1:0] ENT_MAX = EW'(N_ENTRIES - 1);

    // Step the offset, and roll over into the next entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            entry  <= '0;
            offset <= '0;
        end else if (advance) begin
            if (offset == OFF_MAX) begin
                offset <= '0;
                entry  <= entry + 1'b1;
            end else begin
                offset <= offset + 1'b1;
            end
        end
    end

    assign at_end = (offset == OFF_MAX) && (entry == ENT_MAX);

    // Offset never leaves its legal range.
    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= OFF_MAX);
endmodule

// File: rtl/entry_byte_mux.sv
// Module: entry_byte_mux
// Chooses the byte for a given entry and offset. Word w of an entry holds
// address bytes 2w and 2w+1 in its low half, and zero in its high half.
// Entry 0 is broadcast. Assumes four-byte little-endian words.
module entry_byte_mux #(
    parameter int N_ENTRIES   = 16,
    parameter int ENTRY_BYTES = 12,
    localparam int EW = $clog2(N_ENTRIES),
    localparam int OW = $clog2(ENTRY_BYTES)
) (
    input  logic [EW-1:0] entry,
    input  logic [OW-1:0] offset,
    input  logic [47:0]   addr,
    output logic [7:0]    data
);
    logic [OW-3:0] word_idx;
    logic [2:0]    byte_sel;

    // Pick the address byte or zero from the word position.
    always_comb begin
        word_idx = offset[OW-1:2];
        byte_sel = 3'({word_idx, offset[0]});
        data     = 8'h00;
        if (offset[1] == 1'b0) begin
            if (entry == '0) data = 8'hFF;
            else             data = addr[byte_sel*8 +: 8];
        end
    end
endmodule

// File: rtl/setup_frame_gen.sv
// Module: setup_frame_gen (top)
// Streams a perfect-filter setup frame of N_ENTRIES x 12 bytes under a
// valid/ready handshake. Assumes start is a level or pulse sampled only while idle.
module setup_frame_gen
    import setup_frame_pkg::*;
#(
    parameter int N_ENTRIES      = 16,
    parameter int WORDS_PER_ENT  = 3,
    parameter int BYTES_PER_WORD = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [47:0] station_addr,
    output logic [7:0]  m_data,
    output logic        m_valid,
    input  logic        m_ready,
    output logic        m_last,
    output logic        setup_tag
);
    localparam int ENTRY_BYTES = WORDS_PER_ENT * BYTES_PER_WORD;
    localparam int EW = $clog2(N_ENTRIES);
    localparam int OW = $clog2(ENTRY_BYTES);

    fsm_t            state;
    logic [ADDR_W-1:0] addr_q;
    logic [EW-1:0]   entry;
    logic [OW-1:0]   offset;
    logic            at_end;
    logic            fire;
    logic            launch;

    assign fire   = m_valid && m_ready;
    assign launch = (state == ST_IDLE) && start;

    // Control: idle until start, then send until the final byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (launch) begin
            state <= ST_SEND;
        end else if (fire && at_end) begin
            state <= ST_IDLE;
        end
    end

    // Capture the station address only when a frame launches.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (launch) addr_q <= station_addr;
    end

    frame_counter #(.N_ENTRIES(N_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(launch), .advance(fire),
        .entry(entry), .offset(offset), .at_end(at_end)
    );

    entry_byte_mux #(.N_ENTRIES(N_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_mux (
        .entry(entry), .offset(offset), .addr(addr_q), .data(m_data)
    );

    assign m_valid   = (state == ST_SEND);
    assign m_last    = m_valid && at_end;
    assign setup_tag = m_valid;

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
    // R3
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> !m_valid);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && $past(m_valid)) |-> $stable(addr_q));
    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && offset[1]) |-> (m_data == 8'h00));
endmodule

// File: tb/tb_setup_frame_gen.sv
module tb_setup_frame_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] station_addr = '0;
    logic [7:0]  m_data;
    logic        m_valid, m_ready, m_last, setup_tag;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    setup_frame_gen dut (.clk(clk), .rst_n(rst_n), .start(start),
        .station_addr(station_addr), .m_data(m_data), .m_valid(m_valid),
        .m_ready(m_ready), .m_last(m_last), .setup_tag(setup_tag));

    function automatic logic [7:0] exp_byte(int idx, logic [47:0] a);
        int ent = idx / 12;
        int off = idx % 12;
        if (off % 4 >= 2) return 8'h00;
        if (ent == 0) return 8'hFF;
        return a[((off / 4) * 2 + (off % 2)) * 8 +: 8];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one frame; stall_pct is the percentage of cycles with ready low.
    task automatic run_frame(logic [47:0] a, int stall_pct, bit poke);
        int idx = 0;
        int errs = 0;
        logic [7:0] held;
        @(negedge clk);
        station_addr = a; start = 1'b1; m_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        station_addr = ~a;            // R7: change after capture
        while (idx < 192) begin
            if (!m_valid || setup_tag !== m_valid) errs++;          // R9
            if (m_data !== exp_byte(idx, a)) errs++;               // R4 R5 R6
            if (m_last !== (idx == 191)) errs++;                   // R3
            m_ready = ($urandom % 100) >= stall_pct;
            if (poke && idx == 50) start = 1'b1;                   // R8
            held = m_data;
            @(negedge clk);
            start = 1'b0;
            if (m_ready) idx++;
            else if (m_data !== held) errs++;                      // R2
        end
        m_ready = 1'b0;
        check("R2/R3/R4/R5/R6/R7/R9 frame content", errs, 0);
        check("R3 valid drops after last", m_valid, 0);
    endtask

    initial begin
        m_ready = 1'b0;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", m_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle valid", m_valid, 0);
        check("R1 idle tag", setup_tag, 0);
        run_frame(48'h665544332211, 0, 0);
        run_frame(48'hFFFFFFFFFFFF, 0, 0);
        run_frame(48'h000000000000, 40, 0);
        for (int i = 0; i < 3; i++)
            run_frame({$urandom, $urandom} & 48'hFFFFFFFFFFFF, 30, 0);
        run_frame(48'hA1B2C3D4E5F6, 20, 1);
        repeat (4) @(negedge clk);
        check("R8 no second frame", m_valid, 0);
        // R2: valid holds indefinitely while ready is low
        @(negedge clk); start = 1'b1; station_addr = 48'h0102030405AA;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check("R2 stall holds valid", m_valid, 1);
        check("R5 stall holds first byte", m_data, 8'hFF);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (150000) @(posedge clk); fails++; tests++;
                $display("FAIL watchdog actual=timeout expected=done"); end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule